// File: doc/BRIEF.md
# Arithmetic Logic Unit with Status and Control Flags

This block computes a registered result from two operands on either an 8-bit or a 16-bit data path. It performs addition, subtraction, bitwise AND and OR, a one-place left or right shift, and an increment. Next to the result it holds an 8-bit flag register. Five of its bits report on the most recent result: half carry, negative, zero, overflow and carry. The other three are control bits. The arithmetic never changes the control bits; only a separate load port writes them.

Each clock cycle the block takes one operation. The result register updates on every cycle. The status bits update only when the flag-update enable is high. The flag register is packed, from bit 7 down to bit 0, as stop-control (bit 7), extra-mask (bit 6), half carry (bit 5), interrupt-mask (bit 4), negative (bit 3), zero (bit 2), overflow (bit 1) and carry (bit 0).

Top module: `alu_ccr`

## Requirements
- R1: While `rst` is high, and after the first clock edge with it high, `result` is 0 and `ccr` is 8'hD0. That value has the three control bits (7, 6, 4) set and every status bit clear.
- R2: The operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 shift left, 5 shift right (logical), 6 increment. Inputs presented before a rising edge appear on `result` right after that edge. With `wide`=0 only the low 8 bits of each operand take part, and `result[15:8]` is 0. Sums and differences wrap modulo the selected width.
- R3: Carry (bit 0) is set by add on a carry out of the top bit of the selected width. Subtract sets it on a borrow, that is, when a is below b unsigned.
- R4: Overflow (bit 1) for add, subtract and increment is the XOR of the carry into the top bit and the carry out of it.
- R5: Negative (bit 3) copies the top bit of the result: bit 7 in 8-bit mode, bit 15 in 16-bit mode. Zero (bit 2) is set exactly when the result is 0 in the selected width.
- R6: Half carry (bit 5) is written only by an 8-bit add, which sets it to the carry from bit 3 into bit 4. Every other operation leaves it unchanged, and so does every 16-bit operation.
- R7: AND and OR clear overflow, leave carry unchanged, and update negative and zero.
- R8: Increment adds 1 to operand a and ignores b. It updates negative, zero and overflow, and it leaves carry and half carry unchanged, even on wrap-around.
- R9: With `flag_en`=0 and `ccr_ld`=0, `ccr` keeps its value while `result` still updates.
- R10: With `ccr_ld`=1, bits 7, 6 and 4 of `ccr` take the same bits of `ccr_ld_data`. The other bits of `ccr_ld_data` are ignored. Without a load, bits 7, 6 and 4 never change.
- R11: When a load and a flag update fall in the same cycle, both take effect: the control bits come from `ccr_ld_data` and the status bits from the operation.
- R12: Shifts move in a 0. Carry takes the bit shifted out, which is the top bit for a left shift and bit 0 for a right shift. Overflow becomes negative XOR carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| wide | input | 1 | 1 selects the 16-bit path, 0 selects the 8-bit path |
| op | input | 3 | Operation code |
| flag_en | input | 1 | Allows the status bits to update from this operation |
| ccr_ld | input | 1 | Load strobe for the control bits |
| ccr_ld_data | input | 8 | Source of the control bits on a load |
| result | output | 16 | Registered result |
| ccr | output | 8 | Flag register |

## Verification
The control-bit load and the status update from an operation can land in the same clock edge, and they write disjoint parts of one register. The bench provokes this by asserting `ccr_ld` together with `flag_en` on an 8-bit add that produces a half carry. It then requires the whole `ccr` value to show both the loaded control bits and the fresh status bits. A following load with only status bits set in its data, and no operation, confirms that the load touches no status bit.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_INC = 3'd6
  } alu_op_e;

  localparam int CCR_W   = 8;
  localparam int BIT_S   = 7;
  localparam int BIT_X   = 6;
  localparam int BIT_H   = 5;
  localparam int BIT_I   = 4;
  localparam int BIT_N   = 3;
  localparam int BIT_Z   = 2;
  localparam int BIT_V   = 1;
  localparam int BIT_C   = 0;
  localparam logic [CCR_W-1:0] CTRL_MASK = 8'hD0;
  localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic h;
    logic we_v;
    logic we_c;
    logic we_h;
  } flag_upd_t;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_ccr_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          wide,
  input  alu_op_e       op,
  output logic [DW-1:0] res,
  output flag_upd_t     fl
);
  localparam int NLANE = 2;

  logic          is_sub;
  logic          is_inc;
  logic [DW-1:0] b_eff;
  logic          cin;
  logic [4:0]    nib_sum;

  assign is_sub = (op == OP_SUB);
  assign is_inc = (op == OP_INC);
  assign b_eff  = is_sub ? ~b : (is_inc ? DW'(1) : b);
  assign cin    = is_sub;
  assign nib_sum = {1'b0, a[3:0]} + {1'b0, b[3:0]};

  logic [DW-1:0] lane_res [NLANE];
  logic          lane_n   [NLANE];
  logic          lane_z   [NLANE];
  logic          lane_v   [NLANE];
  logic          lane_c   [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = (g == 0) ? NW : DW;
    logic [LW-1:0] la;
    logic [LW-1:0] lb;
    logic [LW-1:0] part;
    logic [LW:0]   full;
    logic [LW-1:0] r;
    logic          c;
    logic          v;
    logic          c_ar;
    logic          v_ar;

    assign la   = a[LW-1:0];
    assign lb   = b_eff[LW-1:0];
    assign part = {1'b0, la[LW-2:0]} + {1'b0, lb[LW-2:0]} + {{(LW-1){1'b0}}, cin};
    assign full = {1'b0, la} + {1'b0, lb} + {{LW{1'b0}}, cin};
    assign c_ar = is_sub ? ~full[LW] : full[LW];
    assign v_ar = part[LW-1] ^ full[LW];

    always_comb begin
      r = full[LW-1:0];
      c = c_ar;
      v = v_ar;
      case (op)
        OP_AND: begin r = la & b[LW-1:0]; v = 1'b0; end
        OP_OR:  begin r = la | b[LW-1:0]; v = 1'b0; end
        OP_SHL: begin
          r = {la[LW-2:0], 1'b0};
          c = la[LW-1];
          v = la[LW-2] ^ la[LW-1];
        end
        OP_SHR: begin
          r = {1'b0, la[LW-1:1]};
          c = la[0];
          v = la[0];
        end
        default: ;
      endcase
    end

    assign lane_res[g] = DW'(r);
    assign lane_n[g]   = r[LW-1];
    assign lane_z[g]   = (r == '0);
    assign lane_v[g]   = v;
    assign lane_c[g]   = c;
  end

  always_comb begin
    res     = wide ? lane_res[1] : lane_res[0];
    fl.n    = wide ? lane_n[1] : lane_n[0];
    fl.z    = wide ? lane_z[1] : lane_z[0];
    fl.v    = wide ? lane_v[1] : lane_v[0];
    fl.c    = wide ? lane_c[1] : lane_c[0];
    fl.h    = nib_sum[4];
    fl.we_v = 1'b1;
    fl.we_c = !(op == OP_AND || op == OP_OR || op == OP_INC);
    fl.we_h = !wide && (op == OP_ADD);
  end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
  import alu_ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flag_en,
  input  flag_upd_t        fl,
  input  logic             ld,
  input  logic [CCR_W-1:0] ld_data,
  output logic [CCR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= CCR_RESET;
    end else begin
      if (ld) begin
        q[BIT_S] <= ld_data[BIT_S];
        q[BIT_X] <= ld_data[BIT_X];
        q[BIT_I] <= ld_data[BIT_I];
      end
      if (flag_en) begin
        q[BIT_N] <= fl.n;
        q[BIT_Z] <= fl.z;
        if (fl.we_v) q[BIT_V] <= fl.v;
        if (fl.we_c) q[BIT_C] <= fl.c;
        if (fl.we_h) q[BIT_H] <= fl.h;
      end
    end
  end
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
  import alu_ccr_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    op_a,
  input  logic [DW-1:0]    op_b,
  input  logic             wide,
  input  logic [2:0]       op,
  input  logic             flag_en,
  input  logic             ccr_ld,
  input  logic [CCR_W-1:0] ccr_ld_data,
  output logic [DW-1:0]    result,
  output logic [CCR_W-1:0] ccr
);
  logic [DW-1:0] core_res;
  flag_upd_t     core_fl;

  alu_core #(.DW(DW), .NW(NW)) u_core (
    .a    (op_a),
    .b    (op_b),
    .wide (wide),
    .op   (alu_op_e'(op)),
    .res  (core_res),
    .fl   (core_fl)
  );

  ccr_reg u_ccr (
    .clk     (clk),
    .rst     (rst),
    .flag_en (flag_en),
    .fl      (core_fl),
    .ld      (ccr_ld),
    .ld_data (ccr_ld_data),
    .q       (ccr)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= core_res;
  end
endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wide,
  input logic [2:0]    op,
  input logic          flag_en,
  input logic          ccr_ld,
  input logic [DW-1:0] result,
  input logic [7:0]    ccr
);
  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && ccr == 8'hD0));

  assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (result[DW-1:NW] == '0));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    flag_en |=> (ccr[2] == (result == '0)));

  assert_neg_flag_R5: assert property (@(posedge clk) disable iff (rst)
    flag_en |=> (ccr[3] == ($past(wide) ? result[DW-1] : result[NW-1])));

  assert_logic_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_en && (op == 3'd2 || op == 3'd3)) |=> (ccr[1] == 1'b0 && ccr[0] == $past(ccr[0])));

  assert_inc_keeps_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd6) |=> (ccr[0] == $past(ccr[0]) && ccr[5] == $past(ccr[5])));

  assert_hold_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (!flag_en && !ccr_ld) |=> $stable(ccr));

  assert_ctrl_untouched_R10: assert property (@(posedge clk) disable iff (rst)
    !ccr_ld |=> (ccr[7:6] == $past(ccr[7:6]) && ccr[4] == $past(ccr[4])));
endmodule

bind alu_ccr alu_ccr_chk #(.DW(DW), .NW(NW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wide    (wide),
  .op      (op),
  .flag_en (flag_en),
  .ccr_ld  (ccr_ld),
  .result  (result),
  .ccr     (ccr)
);

// File: tb/alu_ccr_tb.sv
module alu_ccr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] op_a, op_b;
  logic        wide;
  logic [2:0]  op;
  logic        flag_en;
  logic        ccr_ld;
  logic [7:0]  ccr_ld_data;
  logic [15:0] result;
  logic [7:0]  ccr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_ccr u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .wide(wide), .op(op),
    .flag_en(flag_en), .ccr_ld(ccr_ld), .ccr_ld_data(ccr_ld_data),
    .result(result), .ccr(ccr)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                      input logic w, input logic fe, input logic ld, input logic [7:0] ldd);
    @(negedge clk);
    op = o; op_a = a; op_b = b; wide = w; flag_en = fe; ccr_ld = ld; ccr_ld_data = ldd;
    @(posedge clk);
    #1;
    @(negedge clk);
    flag_en = 1'b0; ccr_ld = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    op = 3'd0; op_a = 16'h1234; op_b = 16'h4321; wide = 1'b1;
    flag_en = 1'b1; ccr_ld = 1'b1; ccr_ld_data = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 result at reset", result, 16'h0000);
    chk("R1 ccr at reset", {8'h00, ccr}, 16'h00D0);
    @(negedge clk);
    rst = 1'b0; flag_en = 1'b0; ccr_ld = 1'b0;
  endtask

  task automatic t_add;
    step(3'd0, 16'h007F, 16'h0001, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R2 add8 result", result, 16'h0080);
    chk("R4 R6 add8 overflow+half", {8'h00, ccr}, 16'h00FA);
    step(3'd0, 16'h12FF, 16'h3401, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R2 add8 upper ignored", result, 16'h0000);
    chk("R3 R5 add8 carry zero", {8'h00, ccr}, 16'h00F5);
    step(3'd0, 16'h0010, 16'h0020, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R6 add8 no half", {8'h00, ccr}, 16'h00D0);
    step(3'd0, 16'h000F, 16'h0001, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R6 add8 half only", {8'h00, ccr}, 16'h00F0);
    step(3'd0, 16'h7FFF, 16'h0001, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R2 add16 result", result, 16'h8000);
    chk("R4 R6 add16 overflow, half kept", {8'h00, ccr}, 16'h00FA);
    step(3'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R3 add16 carry zero", {8'h00, ccr}, 16'h00F5);
  endtask

  task automatic t_sub;
    step(3'd1, 16'h0005, 16'h0007, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R2 sub8 result", result, 16'h00FE);
    chk("R3 sub8 borrow", {8'h00, ccr}, 16'h00F9);
    step(3'd1, 16'h8000, 16'h0001, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R2 sub16 result", result, 16'h7FFF);
    chk("R4 sub16 overflow", {8'h00, ccr}, 16'h00F2);
    step(3'd1, 16'h0042, 16'h0042, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R5 sub8 zero", {8'h00, ccr}, 16'h00F4);
  endtask

  task automatic t_logic;
    step(3'd0, 16'h0080, 16'h0080, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R3 R4 add8 setup", {8'h00, ccr}, 16'h00D7);
    step(3'd2, 16'h00F0, 16'h003C, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R7 and8 result", result, 16'h0030);
    chk("R7 and8 flags", {8'h00, ccr}, 16'h00D1);
    step(3'd3, 16'h8000, 16'h0001, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R7 or16 result", result, 16'h8001);
    chk("R7 or16 flags", {8'h00, ccr}, 16'h00D9);
    step(3'd2, 16'h00FF, 16'hFF00, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R7 and16 zero flags", {8'h00, ccr}, 16'h00D5);
  endtask

  task automatic t_inc;
    step(3'd6, 16'h007F, 16'h0055, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R8 inc8 result", result, 16'h0080);
    chk("R8 inc8 overflow, carry kept", {8'h00, ccr}, 16'h00DB);
    step(3'd0, 16'h0001, 16'h0001, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R2 add8 clear", {8'h00, ccr}, 16'h00D0);
    step(3'd6, 16'h00FF, 16'h0055, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R8 inc8 wrap result", result, 16'h0000);
    chk("R8 inc8 wrap no carry", {8'h00, ccr}, 16'h00D4);
    step(3'd6, 16'h7FFF, 16'h1234, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R8 inc16 result", result, 16'h8000);
    chk("R8 inc16 flags", {8'h00, ccr}, 16'h00DA);
  endtask

  task automatic t_shift;
    step(3'd4, 16'h00C1, 16'h0000, 1'b0, 1'b1, 1'b0, 8'h00);
    chk("R12 shl8 result", result, 16'h0082);
    chk("R12 shl8 flags", {8'h00, ccr}, 16'h00D9);
    step(3'd5, 16'h0001, 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R12 shr16 result", result, 16'h0000);
    chk("R12 shr16 flags", {8'h00, ccr}, 16'h00D7);
    step(3'd4, 16'h4000, 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R12 shl16 result", result, 16'h8000);
    chk("R12 shl16 flags", {8'h00, ccr}, 16'h00DA);
  endtask

  task automatic t_hold;
    step(3'd0, 16'h00FF, 16'h0001, 1'b0, 1'b0, 1'b0, 8'h00);
    chk("R9 result updates", result, 16'h0000);
    chk("R9 flags held", {8'h00, ccr}, 16'h00DA);
  endtask

  task automatic t_load;
    step(3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h00);
    chk("R10 load clears control", {8'h00, ccr}, 16'h000A);
    step(3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 8'hFF);
    chk("R10 load sets control only", {8'h00, ccr}, 16'h00DA);
  endtask

  task automatic t_both;
    step(3'd0, 16'h000F, 16'h0001, 1'b0, 1'b1, 1'b1, 8'h40);
    chk("R11 result", result, 16'h0010);
    chk("R11 load and flags together", {8'h00, ccr}, 16'h0060);
    step(3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h0F);
    chk("R10 status bits of load ignored", {8'h00, ccr}, 16'h0020);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_inc();
    t_shift();
    t_hold();
    t_load();
    t_both();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule